// File: doc/BRIEF.md
# ADC Result Memory Bank

This block holds the results of an ADC sequencer in sixteen slots. Each slot pairs a 12-bit result with an 8-bit control register that tells the sequencer which input channel and reference pair to use and whether the slot closes a sequence. The converter writes a result into a slot through a write strobe and a slot index. Software reaches the bank over a 16-bit peripheral bus. It can read results, write results, and read or write the control registers.

Each slot has a new-data flag. A converter write sets the flag, and any bus access to that slot's result clears it. If the converter overwrites a slot whose result software has not yet consumed, a sticky overflow flag is raised. It stays set until a dedicated clear strobe drops it. While conversion is enabled, the control registers are locked, and bus writes to them are dropped without notice. When the converter and the bus write the same slot in the same cycle, the outcome is fixed: the converter's data is kept and the flag stays set.

Top module: `adc_result_bank`

## Requirements
- R1: A result read returns the 12-bit value in bits 11:0, and bits 15:12 read as zero even when a bus write carried ones there.
- R2: A converter write (`cv_we` high) stores `cv_data` in slot `cv_slot` and sets `slot_flag[cv_slot]` at the same clock edge.
- R3: A bus read or bus write to a slot's result address clears that slot's flag at that edge, unless the converter writes the same slot in that cycle.
- R4: A bus write to result slot i stores `bus_wdata[11:0]` when the converter does not write slot i in the same cycle.
- R5: When the converter and the bus write the same result slot in one cycle, the slot keeps `cv_data` and its flag is set.
- R6: `ovf_flag` rises at the edge where the converter writes a slot whose flag is set and that the bus does not access in that cycle. It then stays high until an edge with `ovf_clr` high and no new overflow event. A new event wins over a clear in the same cycle.
- R7: With `conv_en` low, a bus write to control slot i stores `bus_wdata[7:0]`: bits 3:0 are the channel, bits 6:4 the reference pair, bit 7 end-of-sequence. A read returns this value with bits 15:8 as zero.
- R8: With `conv_en` high, a bus write to any control register leaves it unchanged.
- R9: After reset, all results, control registers, slot flags and the overflow flag are zero.
- R10: Result slot i sits at byte address 0x140+2i and control slot i at 0x100+2i. `bus_rdata` is updated at the edge of a read access (`bus_sel` high, `bus_wr` low), returns contents from before that edge, and holds between reads. A read of any other or odd address returns zero.
- R11: `conv_ctl` shows, with no clock delay, the control register of the slot addressed by `cv_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Conversion enabled; locks control registers |
| cv_we | input | 1 | Converter result write strobe |
| cv_slot | input | 4 | Slot index for the converter write and for `conv_ctl` |
| cv_data | input | 12 | Converter result |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Bus access is a write |
| bus_addr | input | 9 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Registered bus read data |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| slot_flag | output | 16 | Per-slot new-data flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| conv_ctl | output | 8 | Control register of slot `cv_slot` |

## Verification
Flags, overflow, stored results and control values change at the same clock edge that samples the stimulus, so they are due one edge after the stimulus is applied. `bus_rdata` is also due after that one edge, and it carries the contents from before that edge. `conv_ctl` is combinational and follows `cv_slot` within the same cycle. The bench drives inputs on the falling edge, advances a behavioural model at the rising edge, and compares every output 3 ns after that edge, before the next stimulus changes. Directed reads of a result always come one access later than the write they verify.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RES  = 2'd1,
    ACC_CTL  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/adc_bank_decode.sv
module adc_bank_decode
  import adc_bank_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int ADDR_W  = 9,
  parameter logic [ADDR_W-1:0] RES_BASE = 9'h140,
  parameter logic [ADDR_W-1:0] CTL_BASE = 9'h100,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_kind_e         acc_kind,
  output logic [SLOT_W-1:0] acc_idx
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * N_SLOTS);

  logic [ADDR_W-1:0] res_off;
  logic [ADDR_W-1:0] ctl_off;
  logic              res_in;
  logic              ctl_in;

  always_comb begin
    res_off = bus_addr - RES_BASE;
    ctl_off = bus_addr - CTL_BASE;
    res_in  = (bus_addr >= RES_BASE) && (res_off < SPAN) && !bus_addr[0];
    ctl_in  = (bus_addr >= CTL_BASE) && (ctl_off < SPAN) && !bus_addr[0];
  end

  always_comb begin
    acc_kind = ACC_NONE;
    acc_idx  = '0;
    if (bus_sel && res_in) begin
      acc_kind = ACC_RES;
      acc_idx  = res_off[SLOT_W:1];
    end else if (bus_sel && ctl_in) begin
      acc_kind = ACC_CTL;
      acc_idx  = ctl_off[SLOT_W:1];
    end
  end
endmodule

// File: rtl/adc_bank_slot.sv
module adc_bank_slot #(
  parameter int RES_W = 12,
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_en,
  input  logic             cv_hit,
  input  logic [RES_W-1:0] cv_data,
  input  logic             bus_res_hit,
  input  logic             bus_ctl_hit,
  input  logic             bus_wr,
  input  logic [RES_W-1:0] wdata_res,
  input  logic [CTL_W-1:0] wdata_ctl,
  output logic [RES_W-1:0] res_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             flag_q,
  output logic             ovf_evt
);
  logic [RES_W-1:0] res_d;
  logic [CTL_W-1:0] ctl_d;
  logic             flag_d;
  logic             res_en;
  logic             ctl_en;
  logic             flag_en;

  // converter has priority over the bus on the result and flag
  always_comb begin
    res_en  = cv_hit || (bus_res_hit && bus_wr);
    res_d   = cv_hit ? cv_data : wdata_res;
    flag_en = cv_hit || bus_res_hit;
    flag_d  = cv_hit;
    ctl_en  = bus_ctl_hit && bus_wr && !conv_en;
    ctl_d   = wdata_ctl;
    ovf_evt = cv_hit && flag_q && !bus_res_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (res_en)  res_q  <= res_d;
      if (ctl_en)  ctl_q  <= ctl_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assert_cv_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cv_hit |=> (flag_q && res_q == $past(cv_data)));

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_res_hit && !cv_hit) |=> !flag_q);

  assert_bus_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_res_hit && bus_wr && !cv_hit) |=> (res_q == $past(wdata_res)));

  assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_hit && bus_res_hit && bus_wr) |=> (flag_q && res_q == $past(cv_data)));

  assert_ctl_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && bus_ctl_hit && bus_wr) |=> $stable(ctl_q));
endmodule

// File: rtl/adc_bank_readmux.sv
module adc_bank_readmux
  import adc_bank_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int RES_W   = 12,
  parameter int CTL_W   = 8,
  parameter int DATA_W  = 16,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  acc_kind_e                     acc_kind,
  input  logic [SLOT_W-1:0]             acc_idx,
  input  logic [N_SLOTS-1:0][RES_W-1:0] res_all,
  input  logic [N_SLOTS-1:0][CTL_W-1:0] ctl_all,
  output logic [DATA_W-1:0]             rdata_q
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    case (acc_kind)
      ACC_RES: rdata_d = DATA_W'(res_all[acc_idx]);
      ACC_CTL: rdata_d = DATA_W'(ctl_all[acc_idx]);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assert_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[DATA_W-1:RES_W] == '0);

  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_kind == ACC_NONE) |=> (rdata_q == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
#(
  parameter int N_SLOTS = 16,
  parameter int RES_W   = 12,
  parameter int CTL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 9,
  parameter logic [ADDR_W-1:0] RES_BASE = 9'h140,
  parameter logic [ADDR_W-1:0] CTL_BASE = 9'h100,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_en,
  input  logic               cv_we,
  input  logic [SLOT_W-1:0]  cv_slot,
  input  logic [RES_W-1:0]   cv_data,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               ovf_clr,
  output logic [N_SLOTS-1:0] slot_flag,
  output logic               ovf_flag,
  output logic [CTL_W-1:0]   conv_ctl
);
  acc_kind_e                     acc_kind;
  logic [SLOT_W-1:0]             acc_idx;
  logic [N_SLOTS-1:0][RES_W-1:0] res_all;
  logic [N_SLOTS-1:0][CTL_W-1:0] ctl_all;
  logic [N_SLOTS-1:0]            ovf_evt;
  logic                          ovf_d;
  logic                          ovf_en;
  logic                          rd_en;
  logic                          wdata_hi_unused;

  assign wdata_hi_unused = ^bus_wdata[DATA_W-1:RES_W];
  assign rd_en = bus_sel && !bus_wr;

  adc_bank_decode #(
    .N_SLOTS (N_SLOTS),
    .ADDR_W  (ADDR_W),
    .RES_BASE(RES_BASE),
    .CTL_BASE(CTL_BASE)
  ) u_decode (
    .bus_sel (bus_sel),
    .bus_addr(bus_addr),
    .acc_kind(acc_kind),
    .acc_idx (acc_idx)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic cv_hit;
    logic res_hit;
    logic ctl_hit;
    assign cv_hit  = cv_we && (cv_slot == SLOT_W'(i));
    assign res_hit = (acc_kind == ACC_RES) && (acc_idx == SLOT_W'(i));
    assign ctl_hit = (acc_kind == ACC_CTL) && (acc_idx == SLOT_W'(i));

    adc_bank_slot #(
      .RES_W(RES_W),
      .CTL_W(CTL_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_en    (conv_en),
      .cv_hit     (cv_hit),
      .cv_data    (cv_data),
      .bus_res_hit(res_hit),
      .bus_ctl_hit(ctl_hit),
      .bus_wr     (bus_wr),
      .wdata_res  (bus_wdata[RES_W-1:0]),
      .wdata_ctl  (bus_wdata[CTL_W-1:0]),
      .res_q      (res_all[i]),
      .ctl_q      (ctl_all[i]),
      .flag_q     (slot_flag[i]),
      .ovf_evt    (ovf_evt[i])
    );
  end

  adc_bank_readmux #(
    .N_SLOTS(N_SLOTS),
    .RES_W  (RES_W),
    .CTL_W  (CTL_W),
    .DATA_W (DATA_W)
  ) u_readmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .acc_kind(acc_kind),
    .acc_idx (acc_idx),
    .res_all (res_all),
    .ctl_all (ctl_all),
    .rdata_q (bus_rdata)
  );

  assign conv_ctl = ctl_all[cv_slot];

  // a fresh overflow event wins over a simultaneous clear
  always_comb begin
    ovf_en = (|ovf_evt) || ovf_clr;
    ovf_d  = |ovf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else if (ovf_en) ovf_flag <= ovf_d;
  end

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_we && slot_flag[cv_slot] && !(acc_kind == ACC_RES && acc_idx == cv_slot))
      |=> ovf_flag);

  assert_flag_onehot_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cv_we |=> ($countones(slot_flag & ~$past(slot_flag)) == 0));
endmodule

// File: tb/adc_result_bank_tb.sv
module adc_result_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b0;
  logic        cv_we = 1'b0;
  logic [3:0]  cv_slot = '0;
  logic [11:0] cv_data = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic [15:0] bus_rdata;
  logic [15:0] slot_flag;
  logic        ovf_flag;
  logic [7:0]  conv_ctl;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  adc_result_bank u_dut (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .cv_we(cv_we),
    .cv_slot(cv_slot), .cv_data(cv_data), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_clr(ovf_clr), .slot_flag(slot_flag), .ovf_flag(ovf_flag),
    .conv_ctl(conv_ctl)
  );

  // behavioural reference
  int          m_res [16];
  int          m_ctl [16];
  bit          m_flag [16];
  bit          m_ovf;
  int          m_rdata;

  function automatic int res_addr(int i); return 'h140 + 2 * i; endfunction
  function automatic int ctl_addr(int i); return 'h100 + 2 * i; endfunction

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        m_res[i] = 0; m_ctl[i] = 0; m_flag[i] = 0;
      end
      m_ovf = 0; m_rdata = 0;
    end else begin
      int a;
      int ri;
      int ci;
      int rdv;
      bit new_ovf;
      a  = int'(bus_addr);
      ri = -1;
      ci = -1;
      if (bus_sel && a >= 'h140 && a < 'h160 && a % 2 == 0) ri = (a - 'h140) / 2;
      if (bus_sel && a >= 'h100 && a < 'h120 && a % 2 == 0) ci = (a - 'h100) / 2;
      if (bus_sel && !bus_wr) begin
        rdv = 0;
        if (ri >= 0) rdv = m_res[ri];
        if (ci >= 0) rdv = m_ctl[ci];
        m_rdata = rdv;
      end
      new_ovf = cv_we && m_flag[cv_slot] && (ri != int'(cv_slot));
      if (new_ovf) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (ci >= 0 && bus_wr && !conv_en) m_ctl[ci] = int'(bus_wdata[7:0]);
      if (ri >= 0) begin
        if (bus_wr) m_res[ri] = int'(bus_wdata[11:0]);
        m_flag[ri] = 0;
      end
      if (cv_we) begin
        m_res[cv_slot] = int'(cv_data);
        m_flag[cv_slot] = 1;
      end
    end
    #3;
    if (rst_n) begin
      int fl;
      fl = 0;
      for (int i = 0; i < 16; i++) if (m_flag[i]) fl = fl | (1 << i);
      chk(int'(slot_flag), fl, "R3 flags");
      chk(int'(ovf_flag), int'(m_ovf), "R6 overflow");
      chk(int'(bus_rdata), m_rdata, "R10 rdata");
      chk(int'(conv_ctl), m_ctl[cv_slot], "R11 conv_ctl");
    end
  end

  task automatic cyc(input bit ce, input int slot, input int d, input bit sel,
                     input bit wr, input int a, input int wd, input bit clr);
    @(negedge clk);
    cv_we = ce; cv_slot = 4'(slot); cv_data = 12'(d);
    bus_sel = sel; bus_wr = wr; bus_addr = 9'(a); bus_wdata = 16'(wd);
    ovf_clr = clr;
    @(posedge clk);
    #3;
  endtask

  task automatic idle(input int slot);
    cyc(0, slot, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input int a);
    cyc(0, 0, 0, 1, 0, a, 0, 0);
  endtask

  task automatic wr(input int a, input int wd);
    cyc(0, 0, 0, 1, 1, a, wd, 0);
  endtask

  task automatic cvw(input int slot, input int d);
    cyc(1, slot, d, 0, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: everything zero after reset
    rd(res_addr(0));  chk(int'(bus_rdata), 0, "R9 result");
    rd(ctl_addr(15)); chk(int'(bus_rdata), 0, "R9 control");
    chk(int'(slot_flag), 0, "R9 flags");
    chk(int'(ovf_flag), 0, "R9 overflow");

    // R2: converter writes set flags
    cvw(0, 'hABC); cvw(5, 'h5A5); cvw(15, 'hFFF);
    chk(int'(slot_flag), 'h8021, "R2 flags");
    rd(res_addr(15)); chk(int'(bus_rdata), 'h0FFF, "R2 data");
    chk(int'(slot_flag), 'h0021, "R3 read clears");

    // R4, R1: bus write, top nibble dropped
    wr(res_addr(3), 'hFABC);
    rd(res_addr(3)); chk(int'(bus_rdata), 'h0ABC, "R4 R1 bus write");

    // R5: collision on slot 7
    cyc(1, 7, 'h123, 1, 1, res_addr(7), 'h0456, 0);
    chk(int'(slot_flag[7]), 1, "R5 flag kept");
    rd(res_addr(7)); chk(int'(bus_rdata), 'h0123, "R5 data kept");

    // R3: bus write clears flag of slot 5
    wr(res_addr(5), 'h0777);
    chk(int'(slot_flag[5]), 0, "R3 write clears");

    // R6: overflow on slot 0 (flag still set)
    cvw(0, 'h111); chk(int'(ovf_flag), 1, "R6 set");
    idle(0);       chk(int'(ovf_flag), 1, "R6 sticky");
    cyc(0, 0, 0, 0, 0, 0, 0, 1); chk(int'(ovf_flag), 0, "R6 clear");
    cvw(5, 'h001);
    cyc(1, 5, 'h002, 0, 0, 0, 0, 1); chk(int'(ovf_flag), 1, "R6 set beats clear");
    cyc(0, 0, 0, 0, 0, 0, 0, 1); chk(int'(ovf_flag), 0, "R6 clear again");
    cyc(1, 0, 'h222, 1, 0, res_addr(0), 0, 0);
    chk(int'(bus_rdata), 'h0111, "R10 old value on read");
    chk(int'(ovf_flag), 0, "R6 no overflow when read same cycle");

    // R7, R11: control write while unlocked
    wr(ctl_addr(4), 'h12A5);
    rd(ctl_addr(4)); chk(int'(bus_rdata), 'h00A5, "R7 control");
    idle(4); chk(int'(conv_ctl), 'hA5, "R11 conv_ctl");

    // R8: locked control write
    conv_en = 1'b1;
    wr(ctl_addr(4), 'h0033);
    conv_en = 1'b0;
    rd(ctl_addr(4)); chk(int'(bus_rdata), 'h00A5, "R8 locked");

    // R10: unmapped and odd addresses
    rd('h160);       chk(int'(bus_rdata), 0, "R10 past end");
    rd(res_addr(2)); rd('h141); chk(int'(bus_rdata), 0, "R10 odd");
    rd(ctl_addr(4)); rd('h0FE); chk(int'(bus_rdata), 0, "R10 below");

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int kind;
      int a;
      kind = int'($urandom_range(0, 9));
      if (kind < 5)      a = res_addr(int'($urandom_range(0, 15)));
      else if (kind < 8) a = ctl_addr(int'($urandom_range(0, 15)));
      else               a = int'($urandom_range(0, 511));
      conv_en = ($urandom_range(0, 3) == 0);
      cyc(bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
          int'($urandom_range(0, 4095)), bit'($urandom_range(0, 1)),
          bit'($urandom_range(0, 1)), a, int'($urandom_range(0, 65535)),
          ($urandom_range(0, 7) == 0));
    end
    conv_en = 1'b0;
    idle(0); idle(0);

    summary();
    $finish;
  end
endmodule